// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block runs on the reference clock of a fractional clock synthesizer and, once per cycle, produces a signed frequency-deviation word. That word steers the synthesizer's feedback divider. The result is an output clock that sweeps symmetrically above and below the reference frequency along a triangular profile. Spreading the clock's energy this way lowers the peak amplitude of its harmonics.

A three-bit select sets both the peak deviation and the sweep period:

- The rate bit sets the period, measured in reference cycles. Because the period is a fixed cycle count, the sweep rate follows the input frequency.
- The two range bits pick the peak from an irregular table. Two codes in that table are reserved.

An active-low enable switches modulation on and off.

Modulation always starts at zero deviation on the rising slope. A new select takes effect only at a sweep boundary, so a sweep is never cut short.

The controller is a four-state machine:

| State | Meaning |
|---|---|
| `ST_OFF` | Modulation disabled, zero output |
| `ST_RISE` | Deviation climbing from −peak towards +peak |
| `ST_FALL` | Deviation falling from +peak back towards −peak |
| `ST_HOLD` | A reserved code is selected, zero output |

| Transition | Condition |
|---|---|
| Any state → `ST_OFF` | Enable is high |
| `ST_OFF`/`ST_HOLD` → `ST_RISE` | Enabled with a valid code; starts at a quarter period with zero deviation |
| `ST_OFF`/`ST_HOLD` → `ST_HOLD` | Enabled with a reserved code |
| `ST_RISE` → `ST_FALL` | The step that lands on +peak |
| `ST_FALL` → `ST_RISE` | Wrap at the end of the period; reloads −peak for the newly sampled code |
| `ST_FALL` → `ST_HOLD` | Wrap at the end of the period while a reserved code is selected |

Top module: `sscg_profile_gen`

## Requirements
- R1: A synchronous active-low reset forces the deviation output to 0 and the reserved flag to 0 on the next clock edge.
- R2: While the enable input is sampled high at a clock edge, the deviation output after that edge is 0 and the reserved flag is 0.
- R3: The select code is {rate_sel, range_sel[1], range_sel[0]}. The deviation is a signed value in units of 0.001 %. The peak magnitude for each valid code is: 000 → 1125, 001 → 1750, 010 → 750, 011 → 1250, 100 → 1250, 101 → 2000. The output never exceeds ±peak.
- R4: One full sweep lasts 1152 reference cycles when the rate bit is 0, and 1920 cycles when it is 1.
- R5: The sweep is a symmetric triangle with period P and half-period H = P/2. At phase k, for 0 ≤ k < P:
  - for k ≤ H, the output is −peak + floor(2·peak·k/H);
  - for k > H, the output is +peak − floor(2·peak·(k−H)/H).
  The output equals −peak exactly at phase 0 and +peak exactly at phase H.
- R6: Over every complete sweep that starts at phase 0, the deviation values sum to exactly zero.
- R7: Codes 110 and 111 are reserved. When such a code is sampled while enabled, the output is 0 and the reserved flag is 1 until a valid code is sampled.
- R8: The select is sampled only at the period wrap (the edge after phase P−1) or while not sweeping. A change in the middle of a sweep has no effect on the output until the wrap.
- R9: When modulation starts, either after the enable goes low or when leaving a reserved code, the first output is 0 at phase P/4 on the rising slope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_en_n | input | 1 | Modulation enable, active low |
| rate_sel | input | 1 | Sweep-period select (0: 1152 cycles, 1: 1920 cycles) |
| range_sel | input | 2 | Peak-deviation select |
| dev_out | output | DEV_W (16) | Signed deviation in units of 0.001 % |
| rsvd_flag | output | 1 | A reserved select code is active |

## Verification
The bench builds the block with its default parameters: periods of 1152 and 1920 cycles and a 16-bit deviation word. With these values every valid code can be swept through several complete periods within the cycle budget. This means the exact endpoints, the period lengths, the zero sum and the remainder carry of the fractional step are all observed at the true operating scale, rather than on a shrunken period.

The default widths also put mid-sweep select changes, reserved-code entry and exit at a wrap, and disable in the middle of a sweep within reach. Each of these is compared cycle by cycle against a behavioural phase model.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2,
        ST_HOLD = 2'd3
    } sscg_state_t;

    // Peak deviation in units of 0.001 percent, indexed by {rate, r1, r0}.
    function automatic int peak_milli(input int code);
        case (code)
            0:       return 1125;
            1:       return 1750;
            2:       return 750;
            3:       return 1250;
            4:       return 1250;
            5:       return 2000;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/sscg_sel_decode.sv
module sscg_sel_decode #(
    parameter int FAST_PERIOD = 1152,
    parameter int SLOW_PERIOD = 1920,
    parameter int DEV_W       = 16,
    parameter int CNT_W       = 11,
    parameter int REM_W       = 12
) (
    input  logic [2:0]              code,
    output logic signed [DEV_W-1:0] peak,
    output logic [DEV_W-1:0]        step_q,
    output logic [REM_W-1:0]        step_r,
    output logic [REM_W-1:0]        half,
    output logic [CNT_W-1:0]        period_last,
    output logic [CNT_W-1:0]        half_last,
    output logic [CNT_W-1:0]        quarter,
    output logic                    reserved
);
    logic [DEV_W-1:0] pk_tab    [8];
    logic [DEV_W-1:0] q_tab     [8];
    logic [REM_W-1:0] r_tab     [8];
    logic [REM_W-1:0] half_tab  [8];
    logic [CNT_W-1:0] last_tab  [8];
    logic [CNT_W-1:0] hlast_tab [8];
    logic [CNT_W-1:0] qtr_tab   [8];

    for (genvar g = 0; g < 8; g++) begin : g_code
        localparam int PK  = sscg_pkg::peak_milli(g);
        localparam int PER = (g >= 4) ? SLOW_PERIOD : FAST_PERIOD;
        localparam int HF  = PER / 2;
        assign pk_tab[g]    = DEV_W'(PK);
        assign q_tab[g]     = DEV_W'((2 * PK) / HF);
        assign r_tab[g]     = REM_W'((2 * PK) % HF);
        assign half_tab[g]  = REM_W'(HF);
        assign last_tab[g]  = CNT_W'(PER - 1);
        assign hlast_tab[g] = CNT_W'(HF - 1);
        assign qtr_tab[g]   = CNT_W'(HF / 2);
    end

    always_comb begin
        peak        = pk_tab[code];
        step_q      = q_tab[code];
        step_r      = r_tab[code];
        half        = half_tab[code];
        period_last = last_tab[code];
        half_last   = hlast_tab[code];
        quarter     = qtr_tab[code];
        reserved    = code[2] & code[1];
    end

endmodule

// File: rtl/sscg_tri_accum.sv
module sscg_tri_accum #(
    parameter int DEV_W = 16,
    parameter int REM_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    load,
    input  logic signed [DEV_W-1:0] load_val,
    input  logic                    step,
    input  logic                    up,
    input  logic [DEV_W-1:0]        step_q,
    input  logic [REM_W-1:0]        step_r,
    input  logic [REM_W-1:0]        half,
    output logic signed [DEV_W-1:0] dev
);
    logic [REM_W-1:0] rem;
    logic [REM_W:0]   rem_sum;
    logic             carry;
    logic [DEV_W-1:0] delta;

    always_comb begin
        rem_sum = {1'b0, rem} + {1'b0, step_r};
        carry   = (rem_sum >= {1'b0, half});
        delta   = step_q + {{(DEV_W-1){1'b0}}, carry};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            dev <= '0;
            rem <= '0;
        end else if (load) begin
            dev <= load_val;
            rem <= '0;
        end else if (step) begin
            rem <= carry ? REM_W'(rem_sum - {1'b0, half}) : rem_sum[REM_W-1:0];
            dev <= up ? (dev + $signed(delta)) : (dev - $signed(delta));
        end
    end

    // R5: the fractional remainder stays below one half-period
    a_r5_rem_below_half: assert property (@(posedge clk) disable iff (!rst_n)
        rem < half);

endmodule

// File: rtl/sscg_profile_gen.sv
module sscg_profile_gen #(
    parameter int FAST_PERIOD = 1152,
    parameter int SLOW_PERIOD = 1920,
    parameter int DEV_W       = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mod_en_n,
    input  logic                    rate_sel,
    input  logic [1:0]              range_sel,
    output logic signed [DEV_W-1:0] dev_out,
    output logic                    rsvd_flag
);
    import sscg_pkg::*;

    localparam int MAX_PERIOD = (SLOW_PERIOD > FAST_PERIOD) ? SLOW_PERIOD : FAST_PERIOD;
    localparam int CNT_W      = $clog2(MAX_PERIOD);
    localparam int REM_W      = $clog2(MAX_PERIOD) + 1;

    sscg_state_t      state, state_nxt;
    logic [2:0]       code_q;
    logic [CNT_W-1:0] phase, phase_nxt;
    logic             take_code, flag_nxt;
    logic             acc_clear, acc_load, acc_step, acc_up;
    logic signed [DEV_W-1:0] acc_load_val;

    logic [2:0] code_in;
    assign code_in = {rate_sel, range_sel};

    // decode of the incoming select
    logic signed [DEV_W-1:0] in_peak;
    logic [DEV_W-1:0]        in_q;
    logic [REM_W-1:0]        in_r, in_half;
    logic [CNT_W-1:0]        in_last, in_hlast, in_qtr;
    logic                    in_rsv;

    // decode of the latched select
    logic signed [DEV_W-1:0] q_peak;
    logic [DEV_W-1:0]        q_q;
    logic [REM_W-1:0]        q_r, q_half;
    logic [CNT_W-1:0]        q_last, q_hlast, q_qtr;
    logic                    q_rsv;

    sscg_sel_decode #(
        .FAST_PERIOD(FAST_PERIOD), .SLOW_PERIOD(SLOW_PERIOD),
        .DEV_W(DEV_W), .CNT_W(CNT_W), .REM_W(REM_W)
    ) u_dec_in (
        .code(code_in), .peak(in_peak), .step_q(in_q), .step_r(in_r),
        .half(in_half), .period_last(in_last), .half_last(in_hlast),
        .quarter(in_qtr), .reserved(in_rsv)
    );

    sscg_sel_decode #(
        .FAST_PERIOD(FAST_PERIOD), .SLOW_PERIOD(SLOW_PERIOD),
        .DEV_W(DEV_W), .CNT_W(CNT_W), .REM_W(REM_W)
    ) u_dec_q (
        .code(code_q), .peak(q_peak), .step_q(q_q), .step_r(q_r),
        .half(q_half), .period_last(q_last), .half_last(q_hlast),
        .quarter(q_qtr), .reserved(q_rsv)
    );

    // next state and accumulator control
    always_comb begin
        state_nxt    = state;
        phase_nxt    = phase;
        take_code    = 1'b0;
        flag_nxt     = 1'b0;
        acc_clear    = 1'b0;
        acc_load     = 1'b0;
        acc_load_val = '0;
        acc_step     = 1'b0;
        acc_up       = 1'b0;
        if (mod_en_n) begin
            state_nxt = ST_OFF;
            acc_clear = 1'b1;
            phase_nxt = '0;
        end else begin
            unique case (state)
                ST_OFF, ST_HOLD: begin
                    acc_clear = 1'b1;
                    if (in_rsv) begin
                        state_nxt = ST_HOLD;
                        flag_nxt  = 1'b1;
                        phase_nxt = '0;
                    end else begin
                        state_nxt = ST_RISE;
                        take_code = 1'b1;
                        phase_nxt = in_qtr;
                    end
                end
                ST_RISE: begin
                    acc_step  = 1'b1;
                    acc_up    = 1'b1;
                    phase_nxt = phase + 1'b1;
                    if (phase == q_hlast) state_nxt = ST_FALL;
                end
                ST_FALL: begin
                    if (phase == q_last) begin
                        phase_nxt = '0;
                        if (in_rsv) begin
                            state_nxt = ST_HOLD;
                            flag_nxt  = 1'b1;
                            acc_clear = 1'b1;
                        end else begin
                            state_nxt    = ST_RISE;
                            take_code    = 1'b1;
                            acc_load     = 1'b1;
                            acc_load_val = -in_peak;
                        end
                    end else begin
                        acc_step  = 1'b1;
                        phase_nxt = phase + 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // phase, latched select and flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= '0;
            code_q    <= '0;
            rsvd_flag <= 1'b0;
        end else begin
            phase     <= phase_nxt;
            rsvd_flag <= flag_nxt;
            if (take_code) code_q <= code_in;
        end
    end

    sscg_tri_accum #(.DEV_W(DEV_W), .REM_W(REM_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(acc_clear), .load(acc_load),
        .load_val(acc_load_val), .step(acc_step), .up(acc_up),
        .step_q(q_q), .step_r(q_r), .half(q_half), .dev(dev_out)
    );

    // R2: disabled at the previous edge gives zero deviation
    a_r2_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mod_en_n) |-> (dev_out == '0));

    // R7: reserved flag only with zero deviation
    a_r7_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_flag |-> (dev_out == '0));

    // R3: output bounded by the latched peak while sweeping
    a_r3_within_peak: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RISE || state == ST_FALL) |->
            (dev_out <= q_peak && dev_out >= -q_peak));

    // R9: start-up lands on zero on the rising slope
    a_r9_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_OFF || state == ST_HOLD) && !mod_en_n && !in_rsv) |=>
            (dev_out == '0 && state == ST_RISE));

    // R5: rising slope never decreases
    a_r5_rise_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RISE && !mod_en_n) |=> (dev_out >= $past(dev_out)));

    // R8: latched select holds inside a sweep
    a_r8_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en_n && (state == ST_RISE || (state == ST_FALL && phase != q_last)))
            |=> $stable(code_q));

endmodule

// File: tb/tb_sscg_profile_gen.sv
module tb_sscg_profile_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_en_n = 1'b1;
    logic rate_sel = 1'b0;
    logic [1:0] range_sel = 2'b00;
    logic signed [15:0] dev_out;
    logic rsvd_flag;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sscg_profile_gen dut (
        .clk(clk), .rst_n(rst_n), .mod_en_n(mod_en_n), .rate_sel(rate_sel),
        .range_sel(range_sel), .dev_out(dev_out), .rsvd_flag(rsvd_flag)
    );

    function automatic int pk_of(input int c);
        case (c)
            0: return 1125;  1: return 1750;  2: return 750;
            3: return 1250;  4: return 1250;  5: return 2000;
            default: return 0;
        endcase
    endfunction

    function automatic int per_of(input int c);
        return (c >= 4) ? 1920 : 1152;
    endfunction

    function automatic int shape(input int c, input int k);
        int p, h, pk;
        p = per_of(c); h = p / 2; pk = pk_of(c);
        if (k <= h) return -pk + (2 * pk * k) / h;
        return pk - (2 * pk * (k - h)) / h;
    endfunction

    // behavioural model
    bit m_on = 0, m_hold = 0;
    int m_code = 0, m_phase = 0;
    int cyc = 0;

    always @(posedge clk) begin
        int c;
        cyc++;
        c = {rate_sel, range_sel};
        if (!rst_n || mod_en_n) begin
            m_on = 0; m_hold = 0; m_phase = 0;
        end else if (!m_on) begin
            if (c >= 6) begin m_hold = 1; end
            else begin m_hold = 0; m_on = 1; m_code = c; m_phase = per_of(c) / 4; end
        end else if (m_phase == per_of(m_code) - 1) begin
            m_phase = 0;
            if (c >= 6) begin m_on = 0; m_hold = 1; end
            else m_code = c;
        end else begin
            m_phase++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // sweep-level trackers
    bit w_valid = 0;
    int w_code = 0, w_sum = 0, w_min = 0, w_max = 0, w_len = 0;
    bit lm_valid = 0;
    int lm_code = 0, lm_cyc = 0;

    always @(negedge clk) begin
        int e;
        if (rst_n) begin
            e = m_on ? shape(m_code, m_phase) : 0;
            check(cur_req, int'(dev_out), e);
            check({cur_req, "/R7 flag"}, int'(rsvd_flag), int'(m_hold));
        end
        if (rst_n && m_on) begin
            if (m_phase == 0) begin
                if (w_valid && w_len == per_of(w_code)) begin
                    check("R6 zero sum", w_sum, 0);
                    check("R3 max", w_max, pk_of(w_code));
                    check("R3 min", w_min, -pk_of(w_code));
                end
                w_valid = 1; w_code = m_code; w_sum = 0; w_len = 0;
                w_min = 32767; w_max = -32768;
            end
            if (w_valid) begin
                w_sum += int'(dev_out); w_len++;
                if (int'(dev_out) < w_min) w_min = int'(dev_out);
                if (int'(dev_out) > w_max) w_max = int'(dev_out);
            end
            if (int'(dev_out) == -pk_of(m_code)) begin
                if (lm_valid && lm_code == m_code)
                    check("R4 period", cyc - lm_cyc, per_of(m_code));
                lm_valid = 1; lm_code = m_code; lm_cyc = cyc;
            end
        end else begin
            w_valid = 0; lm_valid = 0;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_code(input int c);
        rate_sel  = c[2];
        range_sel = c[1:0];
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        // R1 reset
        run(4);
        check("R1 reset dev", int'(dev_out), 0);
        check("R1 reset flag", int'(rsvd_flag), 0);
        rst_n = 1'b1;
        cur_req = "R2";
        run(8);
        // R9 turn-on, R5 shape, R4 period at code 010
        cur_req = "R9/R5";
        set_code(2);
        mod_en_n = 1'b0;
        @(negedge clk);
        check("R9 start zero", int'(dev_out), 0);
        run(3 * 1152);
        // R8 mid-sweep change ignored until wrap
        cur_req = "R8";
        set_code(5);
        run(900);
        cur_req = "R5";
        run(3 * 1920);
        // remaining valid codes
        for (int c = 0; c < 5; c++) begin
            if (c == 2) continue;
            cur_req = "R3/R5";
            set_code(c);
            run(2 * per_of(c) + 700);
        end
        // R7 reserved codes entered at a wrap
        cur_req = "R7";
        set_code(6);
        run(1500);
        check("R7 flag held", int'(rsvd_flag), 1);
        set_code(7);
        run(20);
        // leaving reserved starts at zero
        cur_req = "R9";
        set_code(1);
        @(negedge clk);
        check("R9 restart zero", int'(dev_out), 0);
        run(1600);
        // R2 disable in mid sweep
        cur_req = "R2";
        mod_en_n = 1'b1;
        @(negedge clk);
        check("R2 disable zero", int'(dev_out), 0);
        run(10);
        cur_req = "R9";
        mod_en_n = 1'b0;
        run(500);
        // R1 reset during sweep
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid sweep dev", int'(dev_out), 0);
        check("R1 reset mid sweep flag", int'(rsvd_flag), 0);
        rst_n = 1'b1;
        mod_en_n = 1'b1;
        run(5);
        finish_up();
    end

endmodule